// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast clock derived from a local oscillator by a programmable integer ratio and hands one pulse per divided period to a phase comparator. The ratio is not held in one large counter. It comes from a prescaler that divides by either 64 or 65, followed by two small counters. The swallow counter (A) decides how many prescaler periods use the longer modulus of 65. The program counter (B) sets how many prescaler periods make up one output period. The total ratio is N = 64·B + A.

To program a wanted ratio N, use B = floor(N/64) and A = N − 64·B. For example, 16672 splits into B = 260 and A = 32, and 6348 splits into B = 99 and A = 12.

The A and B inputs are checked on every clock. At the end of each output period, when the B counter reaches its terminal count, both counters reload. At that point a legal setting on the inputs becomes the active setting. An illegal setting raises an error flag and leaves the previous active setting in use, so a single output period never mixes two settings.

Top module: `swallow_divider`

## Requirements
- R1: With a legal setting active, consecutive rising edges of `div_pulse` are exactly 64·B + A clock cycles apart.
- R2: `div_pulse` is high for exactly one clock cycle per output period.
- R3: In each output period, `mod_ctl` (1 = divide by 65) is high for the first A prescaler periods and low for the rest. It is therefore high for the first 65·A cycles after the pulse, and never high when A = 0.
- R4: Values presented on `b_val`/`a_val` in the middle of a period do not change that period's length. They take effect from the period that starts at the next pulse.
- R5: A setting with B < 3, A ≥ 64 or A ≥ B raises `cfg_err` one cycle after it is presented. The previous active setting keeps governing the output periods.
- R6: `cfg_err` is low one cycle after a legal setting is presented.
- R7: During reset, `div_pulse`, `mod_ctl` and `cfg_err` are low. The active setting after reset is B = 4, A = 0, so the first pulse comes 256 cycles after reset is released.
- R8: The edge settings B = 3 with A = 0 (192 cycles), B = 3 with A = 2 (194 cycles) and B = 64 with A = 63 (4159 cycles) give exact periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-derived clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| b_val | input | 11 | Program counter setting B |
| a_val | input | 7 | Swallow counter setting A |
| div_pulse | output | 1 | One-cycle pulse every N cycles, toward the phase comparator |
| mod_ctl | output | 1 | Prescaler modulus select, 1 = divide by 65 |
| cfg_err | output | 1 | Presented setting is illegal and has been refused |

## Verification
The hardest case to reach is a setting that changes partway through a period. The length of the current period must be unaffected, while the very next period must follow the new setting. To bring this about, the stimulus writes each new setting after a random delay that follows a pulse. It then measures two intervals: the one that was in progress, which must still follow the old ratio, and the one after it, which must follow the new ratio. Refused settings are driven the same way, and the following intervals must keep the last legal ratio.

// File: rtl/swd_pkg.sv
package swd_pkg;

   // Prescaler implementation choice
   typedef enum logic {
      PS_FLAT  = 1'b0,  // one counter compared against 63 or 64
      PS_SPLIT = 1'b1   // base modulus counter plus one inserted extra state
   } ps_style_e;

   // Legality of a requested split of the divide ratio
   function automatic logic split_legal(input int b, input int a,
                                        input int p, input int b_min);
      return (b >= b_min) && (a < p) && (a < b);
   endfunction

endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler
   import swd_pkg::*;
#(
   parameter int        PRE_BITS = 6,
   parameter ps_style_e STYLE    = PS_SPLIT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mod_hi,   // 1: this prescaler period lasts P+1 cycles
   output logic wrap      // last cycle of a prescaler period
);
   localparam int P = 1 << PRE_BITS;

   generate
      if (STYLE == PS_FLAT) begin : g_flat
         logic [PRE_BITS:0] cnt;
         logic [PRE_BITS:0] last;

         assign last = mod_hi ? (PRE_BITS+1)'(P) : (PRE_BITS+1)'(P - 1);
         assign wrap = (cnt == last);

         always_ff @(posedge clk) begin
            if (!rst_n)    cnt <= '0;
            else if (wrap) cnt <= '0;
            else           cnt <= cnt + 1'b1;
         end
      end else begin : g_split
         logic [PRE_BITS-1:0] base;
         logic                extra;
         logic                at_top;

         assign at_top = &base;
         assign wrap   = at_top && (!mod_hi || extra);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               base  <= '0;
               extra <= 1'b0;
            end else if (wrap) begin
               base  <= '0;
               extra <= 1'b0;
            end else if (at_top) begin
               extra <= 1'b1;   // hold one more cycle: the swallowed state
            end else begin
               base  <= base + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/swd_counters.sv
module swd_counters #(
   parameter int B_W   = 11,
   parameter int A_W   = 7,
   parameter int DEF_B = 4,
   parameter int DEF_A = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wrap,
   input  logic [B_W-1:0] ld_b,
   input  logic [A_W-1:0] ld_a,
   output logic           mod_hi,
   output logic           term
);
   logic [B_W-1:0] b_rem;
   logic [A_W-1:0] a_rem;

   assign term   = wrap && (b_rem == B_W'(1));
   assign mod_hi = (a_rem != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_rem <= B_W'(DEF_B);
         a_rem <= A_W'(DEF_A);
      end else if (term) begin
         b_rem <= ld_b;
         a_rem <= ld_a;
      end else if (wrap) begin
         b_rem <= b_rem - 1'b1;
         if (a_rem != '0) a_rem <= a_rem - 1'b1;
      end
   end

endmodule

// File: rtl/swd_cfg.sv
module swd_cfg
   import swd_pkg::*;
#(
   parameter int B_W      = 11,
   parameter int A_W      = 7,
   parameter int PRE_BITS = 6,
   parameter int B_MIN    = 3,
   parameter int DEF_B    = 4,
   parameter int DEF_A    = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [B_W-1:0] b_in,
   input  logic [A_W-1:0] a_in,
   input  logic           load,
   output logic [B_W-1:0] nxt_b,
   output logic [A_W-1:0] nxt_a,
   output logic [B_W-1:0] act_b,
   output logic [A_W-1:0] act_a,
   output logic           err
);
   localparam int P = 1 << PRE_BITS;

   logic legal;

   assign legal = split_legal(int'(b_in), int'(a_in), P, B_MIN);
   assign nxt_b = legal ? b_in : act_b;
   assign nxt_a = legal ? a_in : act_a;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_b <= B_W'(DEF_B);
         act_a <= A_W'(DEF_A);
         err   <= 1'b0;
      end else begin
         err <= !legal;
         if (load) begin
            act_b <= nxt_b;
            act_a <= nxt_a;
         end
      end
   end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
   import swd_pkg::*;
#(
   parameter int        B_W      = 11,
   parameter int        A_W      = 7,
   parameter int        PRE_BITS = 6,
   parameter int        B_MIN    = 3,
   parameter int        DEF_B    = 4,
   parameter int        DEF_A    = 0,
   parameter ps_style_e PS_STYLE = PS_SPLIT
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [B_W-1:0] b_val,
   input  logic [A_W-1:0] a_val,
   output logic           div_pulse,
   output logic           mod_ctl,
   output logic           cfg_err
);
   localparam int P = 1 << PRE_BITS;

   generate
      if (A_W < PRE_BITS) begin : g_bad_aw
         $error("swallow_divider: A_W too narrow for prescaler modulus");
      end
      if (B_MIN < 1) begin : g_bad_bmin
         $error("swallow_divider: B_MIN must be at least 1");
      end
      if (DEF_B < B_MIN || DEF_A >= P || DEF_A >= DEF_B || DEF_A < 0) begin : g_bad_def
         $error("swallow_divider: default split is illegal");
      end
      if (DEF_B >= (1 << B_W)) begin : g_bad_defw
         $error("swallow_divider: DEF_B does not fit B_W");
      end
   endgenerate

   logic           pre_wrap;
   logic           term;
   logic [B_W-1:0] nxt_b;
   logic [A_W-1:0] nxt_a;
   logic [B_W-1:0] act_b;
   logic [A_W-1:0] act_a;

   swd_prescaler #(
      .PRE_BITS (PRE_BITS),
      .STYLE    (PS_STYLE)
   ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .mod_hi (mod_ctl),
      .wrap   (pre_wrap)
   );

   swd_counters #(
      .B_W   (B_W),
      .A_W   (A_W),
      .DEF_B (DEF_B),
      .DEF_A (DEF_A)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrap   (pre_wrap),
      .ld_b   (nxt_b),
      .ld_a   (nxt_a),
      .mod_hi (mod_ctl),
      .term   (term)
   );

   swd_cfg #(
      .B_W      (B_W),
      .A_W      (A_W),
      .PRE_BITS (PRE_BITS),
      .B_MIN    (B_MIN),
      .DEF_B    (DEF_B),
      .DEF_A    (DEF_A)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .b_in  (b_val),
      .a_in  (a_val),
      .load  (term),
      .nxt_b (nxt_b),
      .nxt_a (nxt_a),
      .act_b (act_b),
      .act_a (act_a),
      .err   (cfg_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) div_pulse <= 1'b0;
      else        div_pulse <= term;
   end

endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
   parameter int B_W      = 11,
   parameter int A_W      = 7,
   parameter int PRE_BITS = 6,
   parameter int B_MIN    = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           div_pulse,
   input logic           mod_ctl,
   input logic           cfg_err,
   input logic           pre_wrap,
   input logic           term,
   input logic [B_W-1:0] act_b,
   input logic [A_W-1:0] act_a
);
   localparam int P = 1 << PRE_BITS;

   // R2: output pulse never lasts two cycles
   p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   // R1: a pulse only follows the last cycle of a prescaler period
   p_pulse_on_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |-> $past(pre_wrap));

   // R1: a terminal count is always a prescaler wrap
   p_term_is_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      term |-> pre_wrap);

   // R3: modulus only changes at a prescaler period boundary
   p_mod_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mod_ctl) |-> $past(pre_wrap));

   // R3: the modulus at the start of a period follows the active A
   p_mod_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |-> (mod_ctl == (act_a != '0)));

   // R4: the active setting moves only at a period boundary
   p_hold_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !div_pulse |-> ($stable(act_b) && $stable(act_a)));

   // R5: a refused setting leaves the active one in place
   p_reject_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (div_pulse && cfg_err) |-> ($stable(act_b) && $stable(act_a)));

   // R5: the active setting is always legal
   p_active_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(act_b) >= B_MIN) && (int'(act_a) < P) && (act_a < A_W'(act_b) || int'(act_b) > int'(act_a)));

endmodule

bind swallow_divider swd_checker #(
   .B_W      (B_W),
   .A_W      (A_W),
   .PRE_BITS (PRE_BITS),
   .B_MIN    (B_MIN)
) u_swd_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .div_pulse (div_pulse),
   .mod_ctl   (mod_ctl),
   .cfg_err   (cfg_err),
   .pre_wrap  (pre_wrap),
   .term      (term),
   .act_b     (act_b),
   .act_a     (act_a)
);

// File: tb/swallow_divider_test.sv
module swallow_divider_test;

   localparam int WD_LIMIT = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] b_val = 11'd4;
   logic [6:0]  a_val = 7'd0;
   logic        div_pulse;
   logic        mod_ctl;
   logic        cfg_err;

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   int cur_n;
   int cur_a;
   int last_p;

   always #4 clk = ~clk;   // 125 MHz

   swallow_divider uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .b_val     (b_val),
      .a_val     (a_val),
      .div_pulse (div_pulse),
      .mod_ctl   (mod_ctl),
      .cfg_err   (cfg_err)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc >= WD_LIMIT && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit legal(input int b, input int a);
      return (b >= 3) && (a < 64) && (a < b);
   endfunction

   task automatic wait_pulse(output int at);
      do @(negedge clk); while (!div_pulse);
      at = cyc;
   endtask

   // Present a setting dly cycles into the current period, then measure
   // the interval in progress and the one after it.
   task automatic apply(input int nb, input int na, input int dly, input string tag);
      int p1;
      int p2;
      bit ok;
      ok = legal(nb, na);
      repeat (dly) @(negedge clk);
      b_val = 11'(nb);
      a_val = 7'(na);
      wait_pulse(p1);
      chk(p1 - last_p == cur_n, "R4 period in progress", p1 - last_p, cur_n);
      if (ok) chk(cfg_err == 1'b0, "R6 cfg_err low", int'(cfg_err), 0);
      else    chk(cfg_err == 1'b1, "R5 cfg_err high", int'(cfg_err), 1);
      if (ok) begin
         cur_n = 64 * nb + na;
         cur_a = na;
      end
      wait_pulse(p2);
      chk(p2 - p1 == cur_n, tag, p2 - p1, cur_n);
      chk(mod_ctl == (cur_a != 0), "R3 modulus at period start", int'(mod_ctl), int'(cur_a != 0));
      @(negedge clk);
      chk(div_pulse == 1'b0, "R2 pulse width", int'(div_pulse), 0);
      last_p = p2;
   endtask

   initial begin
      int p0;
      int c0;
      int px;
      void'($urandom(32'd20231));

      // R7: reset state
      repeat (5) @(negedge clk);
      chk(div_pulse == 1'b0, "R7 div_pulse in reset", int'(div_pulse), 0);
      chk(mod_ctl == 1'b0, "R7 mod_ctl in reset", int'(mod_ctl), 0);
      chk(cfg_err == 1'b0, "R7 cfg_err in reset", int'(cfg_err), 0);
      rst_n = 1'b1;
      c0 = cyc;
      wait_pulse(p0);
      chk(p0 - c0 == 256, "R7 first period after reset", p0 - c0, 256);
      last_p = p0;
      cur_n = 256;
      cur_a = 0;

      // R8: edge settings
      apply(3, 0, 10, "R8 B=3 A=0");
      apply(3, 2, 50, "R8 B=3 A=2");
      apply(64, 63, 100, "R8 B=64 A=63");

      // R3: swallow window length for A=2
      apply(5, 2, 0, "R1 B=5 A=2");
      wait_pulse(px);
      chk(mod_ctl == 1'b1, "R3 mod_ctl at start", int'(mod_ctl), 1);
      repeat (129) @(negedge clk);
      chk(mod_ctl == 1'b1, "R3 mod_ctl last swallow cycle", int'(mod_ctl), 1);
      @(negedge clk);
      chk(mod_ctl == 1'b0, "R3 mod_ctl after swallow", int'(mod_ctl), 0);
      last_p = px;

      // R5: refused settings keep the previous ratio
      apply(2, 0, 0, "R5 B<3 keeps ratio");
      apply(100, 64, 20, "R5 A>=64 keeps ratio");
      apply(10, 10, 40, "R5 A=B keeps ratio");
      apply(7, 6, 30, "R6 legal after refusal");

      // R1: random legal sweep
      for (int i = 0; i < 16; i++) begin
         int b;
         int a;
         b = 3 + int'($urandom % 18);
         a = int'($urandom % b);
         apply(b, a, int'($urandom % 100), "R1 random split");
      end

      // R1: larger ratios
      apply(260, 32, 77, "R1 N=16672");
      apply(99, 12, 5, "R1 N=6348");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule